// File: doc/BRIEF.md
# Seven-Slot Pixel Link Serializer

This block turns a parallel pixel stream into one serial display link: four data lanes and one clock lane. Each pixel carries 8-bit red, green and blue channels plus horizontal sync, vertical sync and a data-valid flag. The block runs on a fast clock that gives seven bit slots per pixel period. A separate pixel-clock input, sampled on that fast clock, marks when a new pixel word is present on the inputs.

On the selected edge of the pixel clock the inputs are captured into a holding register. At the last slot of each seven-slot period, the held word is spread over four 7-bit lane words using one of two colour-to-lane mappings. These lane words are loaded into per-lane shift registers and sent most significant slot first. The clock lane sends a fixed seven-slot pattern that is aligned with the data slots.

A 6-bit colour mode switches off the fourth lane. An output enable and the active-low reset each switch off every lane. High impedance is modelled by an enable output beside each serial bit. While a lane's enable is low, its data bit rests at a fixed idle level.

Top module: `pixlink_ser7`

## Requirements
- R1: Each lane word is sent over seven consecutive fast-clock cycles, bit 6 first and bit 0 last. The slot counter runs 0 to 6 and then wraps to 0.
- R2: With `map_sel` high, the lanes carry the following bits. Lane 0 (A) sends {G[2], R[7:2]} as bits 6..0. Lane 1 (B) sends {B[3], B[2], G[7:3]}. Lane 2 (C) sends {de, vsync, hsync, B[7:4]}. Lane 3 (D) sends {0, B[1:0], G[1:0], R[1:0]}.
- R3: With `map_sel` low, the lanes carry the following bits. Lane A sends {G[0], R[5:0]}. Lane B sends {B[1], B[0], G[5:1]}. Lane C sends {de, vsync, hsync, B[5:2]}. Lane D sends {0, B[7:6], G[7:6], R[7:6]}.
- R4: Bit 6 of lane D (its first slot) is always 0.
- R5: While enabled, the clock lane repeats the pattern 1,1,0,0,0,1,1. Its first 1 falls in the same slot as data bit 6.
- R6: With `six_bit` high, `lane_en[3]` is low and `lane_dat[3]` rests at the idle level 0. Lanes 0 to 2 and the clock lane stay enabled.
- R7: With `oe` low, every lane enable and the clock enable are low, and every data bit rests at the idle level 0.
- R8: While `rst_n` is low, every enable is low at once, without waiting for a clock edge.
- R9: The pixel inputs are captured on a rising edge of `pix_clk` when `edge_rise` is high, and on a falling edge when it is low.
- R10: The mapping and the pixel word are sampled only at the seven-slot boundary. Changing `map_sel` while a word is being sent affects only the next pixel.
- R11: After reset the slot counter is 0 and all data lanes send 0 in the first period, while the clock lane sends its pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit-slot clock, seven cycles per pixel |
| rst_n | input | 1 | Asynchronous active-low reset and power-down |
| pix_clk | input | 1 | Pixel clock, sampled on `clk` |
| edge_rise | input | 1 | 1: capture on rising pix_clk edge, 0: on falling |
| red | input | 8 | Red channel |
| grn | input | 8 | Green channel |
| blu | input | 8 | Blue channel |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| de | input | 1 | Data valid |
| map_sel | input | 1 | Colour-to-lane mapping select |
| six_bit | input | 1 | 1: 6-bit colour, lane D off |
| oe | input | 1 | Output enable |
| lane_dat | output | 4 | Serial data bit per lane (0=A..3=D) |
| lane_en | output | 4 | Drive enable per data lane |
| clk_dat | output | 1 | Clock lane serial bit |
| clk_en | output | 1 | Clock lane drive enable |

## Verification
The bench builds the block with its default parameters: the clock pattern 1100011 and an idle level of 0. With these defaults every lane word can be compared as one 7-bit value against the bit lists in R2 and R3.

The pixel clock is high for three slots and low for four, and the inputs change between the two edges. Because of this, the rising-edge and falling-edge capture choices return different words. Each word is checked in the period after it is loaded, while the next word's mapping is already driven on the inputs, which shows that the mapping is sampled only at the boundary.

// File: rtl/pls_pkg.sv
package pls_pkg;
    localparam int CH_W   = 8;
    localparam int SLOT_N = 7;
    localparam int LANE_N = 4;
    localparam int SLOT_W = $clog2(SLOT_N);
    localparam int MAIN_W = CH_W - 2;

    typedef logic [SLOT_N-1:0] lane_word_t;

    typedef struct packed {
        logic [CH_W-1:0] red;
        logic [CH_W-1:0] grn;
        logic [CH_W-1:0] blu;
        logic            hs;
        logic            vs;
        logic            de;
    } pixel_t;
endpackage

// File: rtl/pls_capture.sv
module pls_capture
    import pls_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pix_clk,
    input  logic   edge_rise,
    input  pixel_t px_in,
    output pixel_t px_hold
);
    typedef struct packed {
        logic   pclk;
        pixel_t hold;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    take;

    always_comb begin
        st_d      = st_q;
        st_d.pclk = pix_clk;
        take      = edge_rise ? (pix_clk & ~st_q.pclk) : (~pix_clk & st_q.pclk);
        if (take) begin
            st_d.hold = px_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign px_hold = st_q.hold;

    // R9: a rising-edge capture cannot happen while pix_clk is low
    a_r9_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_rise && !pix_clk) |=> $stable(st_q.hold));
    // R9: a falling-edge capture cannot happen while pix_clk is high
    a_r9_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_rise && pix_clk) |=> $stable(st_q.hold));
endmodule

// File: rtl/pls_lane_map.sv
module pls_lane_map
    import pls_pkg::*;
(
    input  pixel_t                          px,
    input  logic                            map_hi,
    output logic [LANE_N-1:0][SLOT_N-1:0]   lanes
);
    logic [MAIN_W-1:0] main_r, main_g, main_b;
    logic [1:0]        ext_r, ext_g, ext_b;

    function automatic logic [MAIN_W-1:0] pick_main(input logic [CH_W-1:0] c, input logic hi);
        return hi ? c[CH_W-1:2] : c[MAIN_W-1:0];
    endfunction

    function automatic logic [1:0] pick_ext(input logic [CH_W-1:0] c, input logic hi);
        return hi ? c[1:0] : c[CH_W-1:CH_W-2];
    endfunction

    always_comb begin
        main_r = pick_main(px.red, map_hi);
        main_g = pick_main(px.grn, map_hi);
        main_b = pick_main(px.blu, map_hi);
        ext_r  = pick_ext(px.red, map_hi);
        ext_g  = pick_ext(px.grn, map_hi);
        ext_b  = pick_ext(px.blu, map_hi);

        lanes[0] = {main_g[0], main_r};
        lanes[1] = {main_b[1:0], main_g[MAIN_W-1:1]};
        lanes[2] = {px.de, px.vs, px.hs, main_b[MAIN_W-1:2]};
        lanes[3] = {1'b0, ext_b, ext_g, ext_r};
    end
endmodule

// File: rtl/pls_shifter.sv
module pls_shifter
    import pls_pkg::*;
#(
    parameter logic [SLOT_N-1:0] CLK_PATTERN = 7'b1100011
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANE_N-1:0][SLOT_N-1:0] lanes,
    output logic [SLOT_W-1:0]             slot,
    output logic [LANE_N-1:0]             ser,
    output logic                          ck_bit
);
    typedef struct packed {
        logic [SLOT_W-1:0]             slot;
        logic [LANE_N-1:0][SLOT_N-1:0] sh;
        logic [SLOT_N-1:0]             ck;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic   boundary;

    always_comb begin
        st_d     = st_q;
        boundary = (st_q.slot == SLOT_W'(SLOT_N - 1));
        st_d.slot = boundary ? '0 : st_q.slot + SLOT_W'(1);
        st_d.ck   = boundary ? CLK_PATTERN : {st_q.ck[SLOT_N-2:0], st_q.ck[SLOT_N-1]};
        for (int l = 0; l < LANE_N; l++) begin
            st_d.sh[l] = boundary ? lanes[l] : {st_q.sh[l][SLOT_N-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{slot: '0, sh: '0, ck: CLK_PATTERN};
        end else begin
            st_q <= st_d;
        end
    end

    assign slot   = st_q.slot;
    assign ck_bit = st_q.ck[SLOT_N-1];

    for (genvar l = 0; l < LANE_N; l++) begin : g_ser
        assign ser[l] = st_q.sh[l][SLOT_N-1];

        // R10: between boundaries the lane only shifts, nothing new is loaded
        a_r10_hold_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
            !boundary |=> st_q.sh[l][SLOT_N-1] == $past(st_q.sh[l][SLOT_N-2]));
    end

    // R1: slot counter stays within seven slots and wraps after the last
    a_r1_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slot < SLOT_W'(SLOT_N));
    a_r1_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.slot == SLOT_W'(SLOT_N - 1)) |=> st_q.slot == '0);
    // R4: first slot of lane D carries the zero pad
    a_r4_d_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.slot == '0) |-> !ser[LANE_N-1]);
endmodule

// File: rtl/pixlink_ser7.sv
module pixlink_ser7
    import pls_pkg::*;
#(
    parameter logic [SLOT_N-1:0] CLK_PATTERN = 7'b1100011,
    parameter logic              IDLE_LEVEL  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_clk,
    input  logic              edge_rise,
    input  logic [CH_W-1:0]   red,
    input  logic [CH_W-1:0]   grn,
    input  logic [CH_W-1:0]   blu,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              de,
    input  logic              map_sel,
    input  logic              six_bit,
    input  logic              oe,
    output logic [LANE_N-1:0] lane_dat,
    output logic [LANE_N-1:0] lane_en,
    output logic              clk_dat,
    output logic              clk_en
);
    localparam int LANE_D = LANE_N - 1;

    pixel_t                        px_in, px_hold;
    logic [LANE_N-1:0][SLOT_N-1:0] lanes;
    logic [SLOT_W-1:0]             slot;
    logic [LANE_N-1:0]             ser;
    logic                          ck_bit;
    logic                          drive_ok;

    assign px_in = '{red: red, grn: grn, blu: blu, hs: hsync, vs: vsync, de: de};

    pls_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_clk   (pix_clk),
        .edge_rise (edge_rise),
        .px_in     (px_in),
        .px_hold   (px_hold)
    );

    pls_lane_map u_map (
        .px     (px_hold),
        .map_hi (map_sel),
        .lanes  (lanes)
    );

    pls_shifter #(.CLK_PATTERN(CLK_PATTERN)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .lanes  (lanes),
        .slot   (slot),
        .ser    (ser),
        .ck_bit (ck_bit)
    );

    assign drive_ok = oe & rst_n;

    for (genvar l = 0; l < LANE_N; l++) begin : g_lane
        if (l == LANE_D) begin : g_opt
            assign lane_en[l] = drive_ok & ~six_bit;
        end else begin : g_fixed
            assign lane_en[l] = drive_ok;
        end
        assign lane_dat[l] = lane_en[l] ? ser[l] : IDLE_LEVEL;
    end

    assign clk_en  = drive_ok;
    assign clk_dat = clk_en ? ck_bit : IDLE_LEVEL;

    // R5: clock lane follows the pattern in step with the data slots
    a_r5_clk_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> clk_dat == CLK_PATTERN[SLOT_N - 1 - int'(slot)]);
    // R6: 6-bit mode releases lane D only
    a_r6_six_bit_off: assert property (@(posedge clk) disable iff (!rst_n)
        six_bit |-> (!lane_en[LANE_D] && lane_dat[LANE_D] == IDLE_LEVEL));
    a_r6_eight_bit_on: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !six_bit) |-> (lane_en == '1 && clk_en));
    // R7: output enable low releases every lane
    a_r7_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (lane_en == '0 && !clk_en && lane_dat == {LANE_N{IDLE_LEVEL}}));

    // R8: reset releases every lane without a clock
    always_comb begin
        if (!rst_n) begin
            a_r8_reset_off: assert (lane_en == '0 && !clk_en);
        end
    end
endmodule

// File: tb/pixlink_ser7_tb.sv
module pixlink_ser7_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_clk = 1'b0;
    logic       edge_rise = 1'b1;
    logic [7:0] red = '0, grn = '0, blu = '0;
    logic       hsync = 1'b0, vsync = 1'b0, de = 1'b0;
    logic       map_sel = 1'b0, six_bit = 1'b0, oe = 1'b1;
    logic [3:0] lane_dat, lane_en;
    logic       clk_dat, clk_en;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pixlink_ser7 u_dut (
        .clk(clk), .rst_n(rst_n), .pix_clk(pix_clk), .edge_rise(edge_rise),
        .red(red), .grn(grn), .blu(blu), .hsync(hsync), .vsync(vsync), .de(de),
        .map_sel(map_sel), .six_bit(six_bit), .oe(oe),
        .lane_dat(lane_dat), .lane_en(lane_en), .clk_dat(clk_dat), .clk_en(clk_en)
    );

    // entry: {red, grn, blu, hs, vs, de, map}
    localparam logic [27:0] VEC [8] = '{
        {8'hA5, 8'h3C, 8'hF0, 1'b1, 1'b0, 1'b1, 1'b1},
        {8'hA5, 8'h3C, 8'hF0, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'hFF, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'h01, 8'h80, 8'h7E, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'h5A, 8'hC3, 8'h0F, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'h12, 8'h34, 8'h56, 1'b0, 1'b1, 1'b1, 1'b1},
        {8'h81, 8'h42, 8'h24, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    logic [26:0] prev_w   = '0;
    logic        prev_m   = 1'b0;
    string       prev_tag = "R11";

    task automatic check(input bit ok, input string tag, input logic [6:0] got, input logic [6:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got %b expected %b", tag, got, exp);
        end
    endtask

    function automatic logic [6:0] exp_lane(input logic [26:0] w, input logic m, input int l);
        logic [7:0] r, g, b;
        r = w[26:19]; g = w[18:11]; b = w[10:3];
        if (m) begin
            case (l)
                0: return {g[2], r[7], r[6], r[5], r[4], r[3], r[2]};
                1: return {b[3], b[2], g[7], g[6], g[5], g[4], g[3]};
                2: return {w[0], w[1], w[2], b[7], b[6], b[5], b[4]};
                default: return {1'b0, b[1], b[0], g[1], g[0], r[1], r[0]};
            endcase
        end else begin
            case (l)
                0: return {g[0], r[5], r[4], r[3], r[2], r[1], r[0]};
                1: return {b[1], b[0], g[5], g[4], g[3], g[2], g[1]};
                2: return {w[0], w[1], w[2], b[5], b[4], b[3], b[2]};
                default: return {1'b0, b[7], b[6], g[7], g[6], r[7], r[6]};
            endcase
        end
    endfunction

    // One pixel period: samples the word loaded earlier, drives x then y.
    task automatic run_pixel(input logic [26:0] x, input logic [26:0] y, input logic m,
                             input logic esel, input logic six, input logic en,
                             input string tag);
        logic [6:0] got_d [4];
        logic [6:0] got_e [4];
        logic [6:0] got_c, got_ce;
        for (int s = 0; s < 7; s++) begin
            map_sel = m; edge_rise = esel; six_bit = six; oe = en;
            #1;
            for (int l = 0; l < 4; l++) begin
                got_d[l][6-s] = lane_dat[l];
                got_e[l][6-s] = lane_en[l];
            end
            got_c[6-s]  = clk_dat;
            got_ce[6-s] = clk_en;
            if (s == 0) begin
                pix_clk = 1'b1;
                {red, grn, blu, hsync, vsync, de} = x;
            end else if (s == 3) begin
                pix_clk = 1'b0;
                {red, grn, blu, hsync, vsync, de} = y;
            end
            @(negedge clk);
        end
        for (int l = 0; l < 4; l++) begin
            logic       lon;
            logic [6:0] ed;
            string      t;
            lon = en && !(l == 3 && six);
            ed  = lon ? exp_lane(prev_w, prev_m, l) : 7'b0;
            t   = (l == 3 && six) ? "R6" : (!en ? "R7" : prev_tag);
            check(got_d[l] === ed, $sformatf("%s R1 lane %0d data", t, l), got_d[l], ed);
            check(got_e[l] === {7{lon}}, $sformatf("%s lane %0d enable", t, l), got_e[l], {7{lon}});
        end
        check(got_c === (en ? 7'b1100011 : 7'b0), en ? "R5 clock pattern" : "R7 clock lane",
              got_c, en ? 7'b1100011 : 7'b0);
        check(got_ce === {7{en}}, "R7 clock enable", got_ce, {7{en}});
        prev_w   = esel ? x : y;
        prev_m   = m;
        prev_tag = tag;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [26:0] wa, wb;
        wa = {8'hC6, 8'h1B, 8'h93, 1'b1, 1'b0, 1'b1};
        wb = {8'h39, 8'hE4, 8'h6C, 1'b0, 1'b1, 1'b0};

        // R8 / R11: reset state
        repeat (3) @(negedge clk);
        #1;
        check(lane_en === 4'b0, "R8 enables in reset", {3'b0, lane_en}, 7'b0);
        check(lane_dat === 4'b0, "R11 data in reset", {3'b0, lane_dat}, 7'b0);
        check(clk_en === 1'b0, "R8 clock enable in reset", {6'b0, clk_en}, 7'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: R2/R3 mappings, R1 order, R10 pipelining
        for (int k = 0; k < 8; k++) begin
            run_pixel(VEC[k][27:1], VEC[k][27:1], VEC[k][0], 1'b1, 1'b0, 1'b1,
                      VEC[k][0] ? "R2" : "R3");
        end

        // R9: falling-edge capture takes the second-half word
        run_pixel(wa, wb, 1'b1, 1'b0, 1'b0, 1'b1, "R9 falling");
        // R9: rising-edge capture takes the first-half word
        run_pixel(wa, wb, 1'b0, 1'b1, 1'b0, 1'b1, "R9 rising");
        // R10: map flips while the previous word is on the lanes
        run_pixel(wb, wb, 1'b1, 1'b1, 1'b0, 1'b1, "R10 map held");
        run_pixel(wb, wb, 1'b0, 1'b1, 1'b0, 1'b1, "R10 map next");
        // R6: 6-bit mode
        run_pixel(wa, wa, 1'b1, 1'b1, 1'b1, 1'b1, "R2");
        // R7: outputs disabled
        run_pixel(wa, wa, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
        run_pixel(wb, wb, 1'b0, 1'b1, 1'b0, 1'b1, "R3");

        // R8 / R11: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(lane_en === 4'b0, "R8 enables mid-run reset", {3'b0, lane_en}, 7'b0);
        check(clk_en === 1'b0, "R8 clock enable mid-run reset", {6'b0, clk_en}, 7'b0);
        @(negedge clk);
        rst_n   = 1'b1;
        prev_w  = '0;
        prev_tag = "R11";
        run_pixel(wa, wa, 1'b1, 1'b1, 1'b0, 1'b1, "R2");
        run_pixel(wb, wb, 1'b0, 1'b1, 1'b0, 1'b1, "R3");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule